// File: doc/BRIEF.md
# Rectangle Pixel Blit Engine

This is a 2D drawing coprocessor core for 8-bit-per-pixel bitmaps in linear memory. Software programs it through a small register write port with these settings:

- the rectangle size;
- a pitch for the source map and a pitch for the destination map;
- the two start addresses;
- the traversal direction on each axis;
- a 4-bit mix code;
- a fixed foreground colour;
- a draw mode.

Writing a blit opcode to the operation register starts the engine.

For every pixel, the engine reads the source (or takes the fixed colour) and reads the destination. It combines the two with the mix function and writes the result back to the destination. All of this goes through a single request/response memory port, and only one read is in flight at a time. The first or the last pixel of the walk can be left untouched. `busy_o` stays high from the start write until the walk is finished.

Top module: `blit_engine`

## Requirements
- R1: While reset is held and after reset is released, `busy_o` and `mem_req_o` are 0. No memory request is ever issued while `busy_o` is 0.
- R2: A write to register 9 starts an operation only when the engine is idle and bits [3:0] are 8 (plain blit) or 9 (inverted blit). `busy_o` is then 1 in the following cycle. Any other opcode leaves the engine idle.
- R3: The width (register 0) and height (register 1) fields are 12 bits and hold the count minus one, so a rectangle of (W+1) x (H+1) pixels is processed.
- R4: Bit 2 of register 7 set to 1 walks each row right to left (address decreasing by 1). Set to 0, the row is walked left to right.
- R5: Bit 1 of register 7 set to 1 walks rows bottom-up. Set to 0, rows are walked top-down. At each row end, the source and destination addresses return to the row's first column moved by (pitch+1) of their own map (registers 2 and 3) in the chosen direction.
- R6: The result is mix(S,D) with code in register 6 bits [3:0]. The codes are: 0=0, 1=S&D, 2=S&~D, 3=S, 4=~S&D, 5=D, 6=S^D, 7=S|D, 8=~S&~D, 9=S^~D, A=~D, B=S|~D, C=~S, D=~S|D, E=~S|~D, F=all ones.
- R7: Opcode 9 inverts every bit of S before the mix.
- R8: Bit 5 of the opcode write set to 1 takes S from the source map (start address in register 4). Set to 0, S is the fixed colour in register 8 bits [7:0]. The destination start address is in register 5.
- R9: Draw mode in register 7 bits [5:4] selects what is drawn: 0 draws every pixel, 1 leaves the first pixel of the walk unchanged, 2 leaves the last pixel unchanged.
- R10: All register writes are ignored while `busy_o` is 1.
- R11: A memory request holds its address, direction and data until `mem_gnt_i`. A new request never issues while a granted read awaits `mem_rvalid_i`.
- R12: `busy_o` returns to 0 once the walk ends. No memory byte outside the destination pixels written by the walk changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register select |
| reg_wdata_i | input | 32 | Register write data |
| busy_o | output | 1 | Operation in progress |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 22 | Byte address |
| mem_wdata_o | output | 8 | Write pixel |
| mem_gnt_i | input | 1 | Request accepted |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 8 | Read pixel |

## Verification
The bench aims at the row-end address step in every direction combination. An off-by-one there, or a pitch used without the +1, would smear the copy into neighbouring bytes. The full memory is compared against a model, so stray writes show up.

All sixteen mix codes are run. A mix unit with swapped operands would fail on the asymmetric codes such as S&~D.

Suppression is checked in the two draw modes. A design that drops the wrong pixel would leave the opposite corner unchanged.

A parameter write issued while the engine is busy must not alter the running blit or the next one. A design that accepts it would produce a visibly different rectangle.

// File: rtl/blit_pkg.sv
package blit_pkg;
  localparam logic [3:0] RA_WIDTH  = 4'd0;
  localparam logic [3:0] RA_HEIGHT = 4'd1;
  localparam logic [3:0] RA_SPITCH = 4'd2;
  localparam logic [3:0] RA_DPITCH = 4'd3;
  localparam logic [3:0] RA_SRC    = 4'd4;
  localparam logic [3:0] RA_DST    = 4'd5;
  localparam logic [3:0] RA_MIX    = 4'd6;
  localparam logic [3:0] RA_MODE   = 4'd7;
  localparam logic [3:0] RA_FG     = 4'd8;
  localparam logic [3:0] RA_OP     = 4'd9;

  localparam logic [3:0] OP_BLIT     = 4'h8;
  localparam logic [3:0] OP_BLIT_INV = 4'h9;

  localparam int MB_YNEG = 1;
  localparam int MB_XNEG = 2;
  localparam int MB_DRAW = 4;
  localparam int OB_FGSRC = 5;

  localparam logic [1:0] DRAW_ALL     = 2'd0;
  localparam logic [1:0] DRAW_NOFIRST = 2'd1;
  localparam logic [1:0] DRAW_NOLAST  = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PIX, ST_SREQ, ST_SWAIT, ST_DREQ, ST_DWAIT, ST_WREQ, ST_ADV
  } blit_st_e;
endpackage

// File: rtl/blit_regs.sv
module blit_regs
  import blit_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int ADDR_W = 22,
  parameter int PIX_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [3:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              busy_i,
  output logic              start_o,
  output logic [CNT_W-1:0]  width_o,
  output logic [CNT_W-1:0]  height_o,
  output logic [CNT_W-1:0]  spitch_o,
  output logic [CNT_W-1:0]  dpitch_o,
  output logic [ADDR_W-1:0] src_o,
  output logic [ADDR_W-1:0] dst_o,
  output logic [3:0]        mix_o,
  output logic              xneg_o,
  output logic              yneg_o,
  output logic [1:0]        draw_o,
  output logic [PIX_W-1:0]  fg_o,
  output logic              inv_o,
  output logic              fg_src_o
);
  logic wr_ok;
  logic unused_wdata;

  assign unused_wdata = ^wdata_i;
  assign wr_ok   = we_i && !busy_i;
  assign start_o = wr_ok && (addr_i == RA_OP) &&
                   ((wdata_i[3:0] == OP_BLIT) || (wdata_i[3:0] == OP_BLIT_INV));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      width_o  <= '0;
      height_o <= '0;
      spitch_o <= '0;
      dpitch_o <= '0;
      src_o    <= '0;
      dst_o    <= '0;
      mix_o    <= '0;
      xneg_o   <= 1'b0;
      yneg_o   <= 1'b0;
      draw_o   <= DRAW_ALL;
      fg_o     <= '0;
      inv_o    <= 1'b0;
      fg_src_o <= 1'b0;
    end else if (wr_ok) begin
      unique case (addr_i)
        RA_WIDTH:  width_o  <= wdata_i[CNT_W-1:0];
        RA_HEIGHT: height_o <= wdata_i[CNT_W-1:0];
        RA_SPITCH: spitch_o <= wdata_i[CNT_W-1:0];
        RA_DPITCH: dpitch_o <= wdata_i[CNT_W-1:0];
        RA_SRC:    src_o    <= wdata_i[ADDR_W-1:0];
        RA_DST:    dst_o    <= wdata_i[ADDR_W-1:0];
        RA_MIX:    mix_o    <= wdata_i[3:0];
        RA_MODE: begin
          xneg_o <= wdata_i[MB_XNEG];
          yneg_o <= wdata_i[MB_YNEG];
          draw_o <= wdata_i[MB_DRAW+:2];
        end
        RA_FG:     fg_o     <= wdata_i[PIX_W-1:0];
        RA_OP: if (start_o) begin
          inv_o    <= wdata_i[0];
          fg_src_o <= wdata_i[OB_FGSRC];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/blit_walker.sv
module blit_walker #(
  parameter int CNT_W  = 12,
  parameter int ADDR_W = 22
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [CNT_W-1:0]  width_i,
  input  logic [CNT_W-1:0]  height_i,
  input  logic [CNT_W-1:0]  spitch_i,
  input  logic [CNT_W-1:0]  dpitch_i,
  input  logic [ADDR_W-1:0] src_i,
  input  logic [ADDR_W-1:0] dst_i,
  input  logic              xneg_i,
  input  logic              yneg_i,
  output logic [ADDR_W-1:0] src_addr_o,
  output logic [ADDR_W-1:0] dst_addr_o,
  output logic              first_o,
  output logic              last_o
);
  localparam int PAD = ADDR_W - CNT_W;

  logic [CNT_W-1:0]  x_q, y_q;
  logic [ADDR_W-1:0] s_row_q, d_row_q, s_cur_q, d_cur_q;
  logic [ADDR_W-1:0] s_stride, d_stride, s_row_nx, d_row_nx;
  logic              row_end;

  assign s_stride = {{PAD{1'b0}}, spitch_i} + ADDR_W'(1);
  assign d_stride = {{PAD{1'b0}}, dpitch_i} + ADDR_W'(1);
  assign s_row_nx = yneg_i ? s_row_q - s_stride : s_row_q + s_stride;
  assign d_row_nx = yneg_i ? d_row_q - d_stride : d_row_q + d_stride;
  assign row_end  = (x_q == width_i);
  assign last_o   = row_end && (y_q == height_i);
  assign src_addr_o = s_cur_q;
  assign dst_addr_o = d_cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q <= '0;
      y_q <= '0;
      s_row_q <= '0;
      d_row_q <= '0;
      s_cur_q <= '0;
      d_cur_q <= '0;
      first_o <= 1'b0;
    end else if (load_i) begin
      x_q <= '0;
      y_q <= '0;
      s_row_q <= src_i;
      d_row_q <= dst_i;
      s_cur_q <= src_i;
      d_cur_q <= dst_i;
      first_o <= 1'b1;
    end else if (step_i) begin
      first_o <= 1'b0;
      if (row_end) begin
        x_q <= '0;
        y_q <= y_q + CNT_W'(1);
        s_row_q <= s_row_nx;
        d_row_q <= d_row_nx;
        s_cur_q <= s_row_nx;
        d_cur_q <= d_row_nx;
      end else begin
        x_q <= x_q + CNT_W'(1);
        s_cur_q <= xneg_i ? s_cur_q - ADDR_W'(1) : s_cur_q + ADDR_W'(1);
        d_cur_q <= xneg_i ? d_cur_q - ADDR_W'(1) : d_cur_q + ADDR_W'(1);
      end
    end
  end
endmodule

// File: rtl/blit_mix.sv
module blit_mix #(
  parameter int PIX_W = 8
) (
  input  logic [PIX_W-1:0] s_i,
  input  logic [PIX_W-1:0] d_i,
  input  logic [3:0]       code_i,
  output logic [PIX_W-1:0] res_o
);
  // code bit k holds the result for operand pair {s,d} == ~k
  for (genvar i = 0; i < PIX_W; i++) begin : g_bit
    assign res_o[i] = code_i[{~s_i[i], ~d_i[i]}];
  end
endmodule

// File: rtl/blit_engine.sv
module blit_engine
  import blit_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int ADDR_W = 22,
  parameter int PIX_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [3:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic              busy_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [PIX_W-1:0]  mem_wdata_o,
  input  logic              mem_gnt_i,
  input  logic              mem_rvalid_i,
  input  logic [PIX_W-1:0]  mem_rdata_i
);
  blit_st_e st_q, st_d;

  logic              start;
  logic [CNT_W-1:0]  width, height, spitch, dpitch;
  logic [ADDR_W-1:0] src, dst, src_addr, dst_addr;
  logic [3:0]        mix;
  logic              xneg, yneg, inv, fg_src, first, last, skip;
  logic [1:0]        draw;
  logic [PIX_W-1:0]  fg, s_q, d_q, s_op, mix_res;

  blit_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .PIX_W(PIX_W), .DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .busy_i(busy_o),
    .start_o(start), .width_o(width), .height_o(height), .spitch_o(spitch),
    .dpitch_o(dpitch), .src_o(src), .dst_o(dst), .mix_o(mix), .xneg_o(xneg),
    .yneg_o(yneg), .draw_o(draw), .fg_o(fg), .inv_o(inv), .fg_src_o(fg_src)
  );

  blit_walker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_walk (
    .clk_i, .rst_ni,
    .load_i(start), .step_i((st_q == ST_ADV) && !last),
    .width_i(width), .height_i(height), .spitch_i(spitch), .dpitch_i(dpitch),
    .src_i(src), .dst_i(dst), .xneg_i(xneg), .yneg_i(yneg),
    .src_addr_o(src_addr), .dst_addr_o(dst_addr), .first_o(first), .last_o(last)
  );

  assign s_op = inv ? ~(fg_src ? s_q : fg) : (fg_src ? s_q : fg);

  blit_mix #(.PIX_W(PIX_W)) u_mix (
    .s_i(s_op), .d_i(d_q), .code_i(mix), .res_o(mix_res)
  );

  assign busy_o = (st_q != ST_IDLE);
  assign skip   = (first && (draw == DRAW_NOFIRST)) || (last && (draw == DRAW_NOLAST));

  always_comb begin
    st_d        = st_q;
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = dst_addr;
    mem_wdata_o = mix_res;
    unique case (st_q)
      ST_IDLE:  if (start) st_d = ST_PIX;
      ST_PIX:   st_d = skip ? ST_ADV : (fg_src ? ST_SREQ : ST_DREQ);
      ST_SREQ: begin
        mem_req_o  = 1'b1;
        mem_addr_o = src_addr;
        if (mem_gnt_i) st_d = ST_SWAIT;
      end
      ST_SWAIT: if (mem_rvalid_i) st_d = ST_DREQ;
      ST_DREQ: begin
        mem_req_o = 1'b1;
        if (mem_gnt_i) st_d = ST_DWAIT;
      end
      ST_DWAIT: if (mem_rvalid_i) st_d = ST_WREQ;
      ST_WREQ: begin
        mem_req_o = 1'b1;
        mem_we_o  = 1'b1;
        if (mem_gnt_i) st_d = ST_ADV;
      end
      ST_ADV:   st_d = last ? ST_IDLE : ST_PIX;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
      s_q  <= '0;
      d_q  <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_SWAIT && mem_rvalid_i) s_q <= mem_rdata_i;
      if (st_q == ST_DWAIT && mem_rvalid_i) d_q <= mem_rdata_i;
    end
  end
endmodule

// File: rtl/blit_engine_chk.sv
module blit_engine_chk #(
  parameter int ADDR_W = 22,
  parameter int PIX_W  = 8,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [3:0]        reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic              busy_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [PIX_W-1:0]  mem_wdata_o,
  input logic              mem_gnt_i,
  input logic              mem_rvalid_i
);
  logic rd_pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_pend_q <= 1'b0;
    else if (mem_req_o && mem_gnt_i && !mem_we_o) rd_pend_q <= 1'b1;
    else if (mem_rvalid_i) rd_pend_q <= 1'b0;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o); // R1

  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !busy_o && reg_addr_i == 4'd9 &&
     (reg_wdata_i[3:0] == 4'h8 || reg_wdata_i[3:0] == 4'h9)) |=> busy_o); // R2

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) &&
       (!mem_we_o || $stable(mem_wdata_o)))); // R11

  AST_ONE_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_pend_q |-> !mem_req_o); // R11
endmodule

bind blit_engine blit_engine_chk #(.ADDR_W(ADDR_W), .PIX_W(PIX_W), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .reg_wdata_i(reg_wdata_i), .busy_o(busy_o), .mem_req_o(mem_req_o),
  .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
  .mem_gnt_i(mem_gnt_i), .mem_rvalid_i(mem_rvalid_i)
);

// File: tb/blit_engine_test.sv
`timescale 1ns/1ps
module blit_engine_test;
  typedef struct packed {
    logic [11:0] w, h, sp, dp;
    logic [21:0] src, dst;
    logic [3:0]  mix;
    logic        xn, yn;
    logic [1:0]  draw;
    logic        inv, fgs;
    logic [7:0]  fg;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{12'd3, 12'd2, 12'd15, 12'd15, 22'h040, 22'h240, 4'h3, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 8'h00},
    '{12'd4, 12'd1, 12'd15, 12'd31, 22'h047, 22'h247, 4'h6, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1, 8'h00},
    '{12'd2, 12'd3, 12'd15, 12'd15, 22'h0F0, 22'h2F0, 4'h7, 1'b0, 1'b1, 2'd0, 1'b0, 1'b1, 8'h00},
    '{12'd3, 12'd3, 12'd15, 12'd15, 22'h0F3, 22'h3F3, 4'h1, 1'b1, 1'b1, 2'd0, 1'b0, 1'b1, 8'h00},
    '{12'd3, 12'd1, 12'd7,  12'd15, 22'h060, 22'h260, 4'h3, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1, 8'h00},
    '{12'd2, 12'd2, 12'd15, 12'd15, 22'h060, 22'h260, 4'h6, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 8'h5A},
    '{12'd2, 12'd1, 12'd15, 12'd15, 22'h050, 22'h250, 4'hF, 1'b0, 1'b0, 2'd1, 1'b0, 1'b1, 8'h00},
    '{12'd2, 12'd1, 12'd15, 12'd15, 22'h050, 22'h250, 4'h0, 1'b1, 1'b0, 2'd2, 1'b0, 1'b1, 8'h00},
    '{12'd0, 12'd0, 12'd0,  12'd0,  22'h011, 22'h211, 4'h9, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 8'h00}
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        busy, mem_req, mem_we, mem_gnt, mem_rvalid = 1'b0;
  logic [21:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata = '0;
  logic [1:0]  gcnt = '0;
  logic        fill = 1'b0;
  int          seed_q = 0;
  logic [7:0]  mem  [1024];
  logic [7:0]  expm [1024];
  int total = 0, bad = 0, viol = 0, cyc = 0;
  logic        pend = 1'b0, hold_q = 1'b0;
  logic [21:0] hold_a = '0;

  always #5 clk = ~clk;

  blit_engine uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .busy_o(busy), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_gnt_i(mem_gnt),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata)
  );

  function automatic logic [7:0] pat(int a, int s);
    return 8'((a * 37 + s * 11 + (a >> 4)) ^ (a >> 2));
  endfunction

  function automatic logic [7:0] mixf(logic [3:0] c, logic [7:0] s, logic [7:0] d);
    case (c)
      4'h0: return 8'h00;    4'h1: return s & d;
      4'h2: return s & ~d;   4'h3: return s;
      4'h4: return ~s & d;   4'h5: return d;
      4'h6: return s ^ d;    4'h7: return s | d;
      4'h8: return ~s & ~d;  4'h9: return s ^ ~d;
      4'hA: return ~d;       4'hB: return s | ~d;
      4'hC: return ~s;       4'hD: return ~s | d;
      4'hE: return ~s | ~d;  default: return 8'hFF;
    endcase
  endfunction

  assign mem_gnt = (gcnt != 2'd3);

  always @(posedge clk) begin
    gcnt <= gcnt + 2'd1;
    mem_rvalid <= 1'b0;
    if (fill) begin
      for (int i = 0; i < 1024; i++) mem[i] <= pat(i, seed_q);
    end else if (mem_req && mem_gnt) begin
      if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
      else begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem[mem_addr[9:0]];
      end
    end
    // R11 bench-side handshake monitor
    if (rst_n) begin
      if (pend && mem_req) viol <= viol + 1;
      if (hold_q && (!mem_req || mem_addr != hold_a)) viol <= viol + 1;
      if (!busy && mem_req) viol <= viol + 1;
    end
    if (mem_rvalid) pend <= 1'b0;
    if (mem_req && mem_gnt && !mem_we) pend <= 1'b1;
    hold_q <= mem_req && !mem_gnt;
    hold_a <= mem_addr;
  end

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      $display("FAIL R12 watchdog expired act=%0d exp<=150000", cyc);
      bad = bad + 1;
      total = total + 1;
      summary();
      $finish;
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic fill_mem(int seed);
    @(negedge clk);
    seed_q = seed; fill = 1'b1;
    @(negedge clk);
    fill = 1'b0;
  endtask

  task automatic prog(vec_t v);
    wr(4'd0, 32'(v.w));  wr(4'd1, 32'(v.h));
    wr(4'd2, 32'(v.sp)); wr(4'd3, 32'(v.dp));
    wr(4'd4, 32'(v.src)); wr(4'd5, 32'(v.dst));
    wr(4'd6, 32'(v.mix)); wr(4'd8, 32'(v.fg));
    wr(4'd7, {26'd0, v.draw, 1'b0, v.xn, v.yn, 1'b0});
  endtask

  task automatic go(vec_t v);
    wr(4'd9, {26'd0, v.fgs, 1'b0, 3'b100, v.inv});
  endtask

  task automatic wait_done(string req);
    int t = 0;
    while (busy && t < 5000) begin @(negedge clk); t++; end
    chk(!busy, req, "busy did not clear", t, 5000);
  endtask

  task automatic model(vec_t v, int seed);
    int tot, k, sa, da, sw, dw;
    logic [7:0] s;
    for (int i = 0; i < 1024; i++) expm[i] = pat(i, seed);
    tot = (int'(v.w) + 1) * (int'(v.h) + 1);
    k = 0;
    for (int y = 0; y <= int'(v.h); y++) begin
      for (int x = 0; x <= int'(v.w); x++) begin
        sw = v.yn ? -y * (int'(v.sp) + 1) : y * (int'(v.sp) + 1);
        dw = v.yn ? -y * (int'(v.dp) + 1) : y * (int'(v.dp) + 1);
        sa = (int'(v.src) + sw + (v.xn ? -x : x)) & 1023;
        da = (int'(v.dst) + dw + (v.xn ? -x : x)) & 1023;
        if (!((k == 0 && v.draw == 2'd1) || (k == tot - 1 && v.draw == 2'd2))) begin
          s = v.fgs ? pat(sa, seed) : v.fg;
          if (v.inv) s = ~s;
          expm[da] = mixf(v.mix, s, pat(da, seed));
        end
        k++;
      end
    end
  endtask

  task automatic compare(string req, string what);
    int nbad = 0, first = 0;
    for (int i = 0; i < 1024; i++)
      if (mem[i] !== expm[i]) begin
        if (nbad == 0) first = i;
        nbad++;
      end
    chk(nbad == 0, req, $sformatf("%s mismatch at %0h", what, first),
        int'(mem[first]), int'(expm[first]));
  endtask

  task automatic run(vec_t v, int seed, string req);
    fill_mem(seed);
    prog(v);
    model(v, seed);
    go(v);
    chk(busy, "R2", "busy after start", int'(busy), 1);
    wait_done("R12");
    compare(req, "result");
  endtask

  initial begin
    vec_t v;
    string tags [NV] = '{"R3", "R4", "R5", "R4 R5", "R7", "R8", "R9", "R9", "R3"};
    repeat (3) @(negedge clk);
    chk(!busy && !mem_req, "R1", "state in reset", {busy, mem_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mem_req, "R1", "state after reset", {busy, mem_req}, 0);

    // vector table walk
    for (int i = 0; i < NV; i++) run(VEC[i], i + 3, tags[i]);

    // R6: every mix code on a 2x2 rectangle
    for (int c = 0; c < 16; c++) begin
      v = VEC[0];
      v.w = 12'd1; v.h = 12'd1; v.mix = 4'(c);
      run(v, 40 + c, "R6");
    end

    // R2: non-blit opcode does not start
    fill_mem(77);
    wr(4'd9, 32'h0000_0005);
    repeat (20) begin
      @(negedge clk);
      if (busy || mem_req) break;
    end
    chk(!busy && !mem_req, "R2", "opcode 5 started engine", {busy, mem_req}, 0);
    for (int i = 0; i < 1024; i++) expm[i] = pat(i, 77);
    compare("R2", "memory after opcode 5");

    // R10: writes while busy ignored, in this blit and the next
    v = VEC[0];
    fill_mem(90);
    prog(v);
    model(v, 90);
    go(v);
    wr(4'd6, 32'h0);
    wr(4'd0, 32'h0);
    wr(4'd9, 32'h0000_0009);
    wait_done("R10");
    compare("R10", "blit with busy writes");
    fill_mem(91);
    model(v, 91);
    go(v);
    wait_done("R10");
    compare("R10", "next blit keeps old settings");

    // R12: idle afterwards
    repeat (10) @(negedge clk);
    chk(!busy && !mem_req, "R12", "idle after done", {busy, mem_req}, 0);
    chk(viol == 0, "R11", "handshake violations", viol, 0);

    summary();
    $finish;
  end
endmodule